// File: doc/BRIEF.md
# Interrupt Relay Ring Writer

This block places interrupt event codes into a ring queue that lives in a small byte-wide shared memory. Software on the consumer side owns the read position (the head byte). This block owns the number of pending entries (the count byte). Each accepted request carries an 8-bit type code. The block reads the head byte, then reads the count byte, and computes the target slot as the sum of the two modulo 52. It writes the type code into that slot of the slot array, then writes the count back incremented by one.

The block drives a single byte port with separate read and write strobes. Read data comes back one cycle after a read strobe. Requests enter through a valid/ready handshake, and a request that arrives while a post is in progress waits until the block returns to idle. An enable input reports whether the shared region has been set up. A request accepted while this input is low is discarded without touching memory.

Top module: `irq_ring_poster`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1 and neither `mem_rd_o` nor `mem_wr_o` is asserted.
- R2: A request accepted with `enable_i` high starts a read of byte offset 0 (head) in the next cycle. The read of byte offset 1 (count) follows in the cycle after that. `mem_rdata_i` is taken to hold the addressed byte one cycle after each read strobe.
- R3: The type code is written to byte offset 12 + ((head + count) mod 52), where head and count are the values read as unsigned 8-bit numbers.
- R4: The count byte at offset 1 is written with (count + 1) mod 256. A count of 255 wraps to 0 with no other indication.
- R5: The byte at offset 0 is never written.
- R6: A request accepted while `enable_i` is low is dropped. No read or write strobe follows, and `req_ready_o` stays 1.
- R7: After an enabled request is accepted, `req_ready_o` is 0 for exactly 5 cycles. A request held valid during that time is accepted when ready returns.
- R8: Each enabled post makes exactly four accesses, in this order: read head, read count, write slot, write count.
- R9: Read and write strobes are never asserted in the same cycle.

Port order for the table below follows the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Shared region is set up; sampled when a request is accepted |
| req_valid_i | input | 1 | Interrupt request present |
| req_type_i | input | 8 | Event type code to post |
| req_ready_o | output | 1 | Block can accept a request this cycle |
| mem_rd_o | output | 1 | Byte read strobe |
| mem_wr_o | output | 1 | Byte write strobe |
| mem_addr_o | output | ADDR_W | Byte offset within the shared region |
| mem_wdata_o | output | 8 | Write data byte |
| mem_rdata_i | input | 8 | Read data byte, valid one cycle after a read strobe |

## Verification
The assertions take for granted that the shared memory returns read data with exactly one cycle of latency. They also assume that nothing else writes the head or count bytes between the block's read of them and its write-back. The bench holds to both. Its memory model is a plain registered-read array, and it changes the head and count bytes only while the block is idle. It sweeps every head value a correct consumer can hold (0 to 51) against every count value, and it adds out-of-range head values and back-to-back held requests.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HEAD,
        ST_RD_CNT,
        ST_CAPT,
        ST_WR_SLOT,
        ST_WR_CNT
    } post_state_e;

    typedef struct packed {
        post_state_e              st;
        logic [BYTE_W-1:0]        kind;
        logic [BYTE_W-1:0]        head;
        logic [BYTE_W-1:0]        count;
    } post_regs_t;

endpackage

// File: rtl/irq_ring_slot.sv
module irq_ring_slot #(
    parameter int unsigned SLOTS = 52,
    parameter int unsigned W     = 8
) (
    input  logic [W-1:0] head_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] slot_o
);

    localparam int unsigned SUM_W   = W + 1;
    localparam int unsigned MAX_SUM = 2 * ((1 << W) - 1);
    localparam int unsigned STEPS   = MAX_SUM / SLOTS;

    logic [SUM_W-1:0] part [0:STEPS];

    assign part[0] = {1'b0, head_i} + {1'b0, count_i};

    for (genvar i = 0; i < STEPS; i++) begin : g_fold
        assign part[i+1] = (part[i] >= SUM_W'(SLOTS)) ? (part[i] - SUM_W'(SLOTS)) : part[i];
    end

    assign slot_o = part[STEPS][W-1:0];

endmodule

// File: rtl/irq_ring_seq.sv
module irq_ring_seq
    import irq_ring_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned HEAD_OFF  = 0,
    parameter int unsigned COUNT_OFF = 1,
    parameter int unsigned SLOT_BASE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              req_valid_i,
    input  logic [BYTE_W-1:0] req_type_i,
    output logic              req_ready_o,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic [BYTE_W-1:0] slot_i,
    output logic [BYTE_W-1:0] head_o,
    output logic [BYTE_W-1:0] count_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o
);

    post_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        req_ready_o = (r_q.st == ST_IDLE);
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i && enable_i) begin
                    r_d.kind = req_type_i;
                    r_d.st   = ST_RD_HEAD;
                end
            end
            ST_RD_HEAD: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = ADDR_W'(HEAD_OFF);
                r_d.st     = ST_RD_CNT;
            end
            ST_RD_CNT: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = ADDR_W'(COUNT_OFF);
                r_d.head   = rdata_i;
                r_d.st     = ST_CAPT;
            end
            ST_CAPT: begin
                r_d.count = rdata_i;
                r_d.st    = ST_WR_SLOT;
            end
            ST_WR_SLOT: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = ADDR_W'(SLOT_BASE) + ADDR_W'(slot_i);
                mem_wdata_o = r_q.kind;
                r_d.st      = ST_WR_CNT;
            end
            ST_WR_CNT: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = ADDR_W'(COUNT_OFF);
                mem_wdata_o = r_q.count + BYTE_W'(1);
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, kind: '0, head: '0, count: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign head_o  = r_q.head;
    assign count_o = r_q.count;

endmodule

// File: rtl/irq_ring_poster.sv
module irq_ring_poster
    import irq_ring_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SLOTS     = 52,
    parameter int unsigned HEAD_OFF  = 0,
    parameter int unsigned COUNT_OFF = 1,
    parameter int unsigned SLOT_BASE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              req_valid_i,
    input  logic [7:0]        req_type_i,
    output logic              req_ready_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);

    logic [BYTE_W-1:0] head_w;
    logic [BYTE_W-1:0] count_w;
    logic [BYTE_W-1:0] slot_w;

    irq_ring_slot #(
        .SLOTS (SLOTS),
        .W     (BYTE_W)
    ) i_slot (
        .head_i  (head_w),
        .count_i (count_w),
        .slot_o  (slot_w)
    );

    irq_ring_seq #(
        .ADDR_W    (ADDR_W),
        .HEAD_OFF  (HEAD_OFF),
        .COUNT_OFF (COUNT_OFF),
        .SLOT_BASE (SLOT_BASE)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .req_valid_i (req_valid_i),
        .req_type_i  (req_type_i),
        .req_ready_o (req_ready_o),
        .rdata_i     (mem_rdata_i),
        .slot_i      (slot_w),
        .head_o      (head_w),
        .count_o     (count_w),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

endmodule

// File: rtl/irq_ring_checker.sv
module irq_ring_checker #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SLOTS     = 52,
    parameter int unsigned HEAD_OFF  = 0,
    parameter int unsigned COUNT_OFF = 1,
    parameter int unsigned SLOT_BASE = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [ADDR_W-1:0] mem_addr_o
);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    assert_head_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o != ADDR_W'(HEAD_OFF)));

    assert_drop_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !enable_i) |=> (req_ready_o && !mem_rd_o && !mem_wr_o));

    assert_start_head_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && enable_i) |=> (mem_rd_o && mem_addr_o == ADDR_W'(HEAD_OFF)));

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> !req_ready_o);

    assert_slot_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !$past(mem_wr_o)) |->
            (mem_addr_o >= ADDR_W'(SLOT_BASE) && mem_addr_o < ADDR_W'(SLOT_BASE + SLOTS)));

    assert_count_after_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && $past(mem_wr_o)) |-> (mem_addr_o == ADDR_W'(COUNT_OFF)));

endmodule

bind irq_ring_poster irq_ring_checker #(
    .ADDR_W    (ADDR_W),
    .SLOTS     (SLOTS),
    .HEAD_OFF  (HEAD_OFF),
    .COUNT_OFF (COUNT_OFF),
    .SLOT_BASE (SLOT_BASE)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/test_irq_ring_poster.sv
module test_irq_ring_poster;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [7:0] req_type_i = '0;
    logic       req_ready_o;
    logic       mem_rd_o;
    logic       mem_wr_o;
    logic [7:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic [7:0] mem_rdata_i = '0;

    logic [7:0] mem [0:255];

    int nvec = 0;
    int nfail = 0;
    int nops = 0;
    int nbusy = 0;
    logic       op_rd   [0:7];
    logic [7:0] op_addr [0:7];

    always #5 clk = ~clk;

    irq_ring_poster i_irq_ring_poster (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .req_valid_i (req_valid_i),
        .req_type_i  (req_type_i),
        .req_ready_o (req_ready_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // shared byte memory with one cycle read latency
    always @(posedge clk) begin
        if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    end

    // access and busy monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_o || mem_wr_o) begin
                if (nops < 8) begin
                    op_rd[nops]   <= mem_rd_o;
                    op_addr[nops] <= mem_addr_o;
                end
                nops <= nops + 1;
            end
            if (!req_ready_o) nbusy <= nbusy + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        nops  = 0;
        nbusy = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
    endtask

    // one post with given head, count and type; checks all per-post requirements
    task automatic post_one(input int h, input int c, input int t);
        int slot;
        int seq_ok;
        slot = (h + c) % 52;
        clear_mon();
        mem[0] = 8'(h);
        mem[1] = 8'(c);
        mem[12 + slot] = ~8'(t);
        enable_i    = 1'b1;
        req_valid_i = 1'b1;
        req_type_i  = 8'(t);
        @(negedge clk);
        req_valid_i = 1'b0;
        wait_idle();
        chk(mem[12 + slot] == 8'(t), "R3", "slot byte", int'(mem[12 + slot]), t);
        chk(mem[1] == 8'((c + 1) % 256), "R4", "count byte", int'(mem[1]), (c + 1) % 256);
        chk(mem[0] == 8'(h), "R5", "head byte", int'(mem[0]), h);
        chk(nbusy == 5, "R7", "busy cycles", nbusy, 5);
        seq_ok = (nops == 4) && op_rd[0] && op_addr[0] == 8'd0 && op_rd[1] && op_addr[1] == 8'd1
                 && !op_rd[2] && op_addr[2] == 8'(12 + slot) && !op_rd[3] && op_addr[3] == 8'd1;
        chk(seq_ok != 0, "R8", "access count/order ok", nops, 4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);
        chk(!mem_rd_o && !mem_wr_o, "R1", "strobes after reset", int'(mem_rd_o) + int'(mem_wr_o), 0);

        // R2: first access after acceptance is head read
        mem[0] = 8'd3; mem[1] = 8'd4;
        enable_i = 1'b1; req_valid_i = 1'b1; req_type_i = 8'h11;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(mem_rd_o && mem_addr_o == 8'd0, "R2", "head read after accept", int'(mem_addr_o), 0);
        chk(!mem_wr_o, "R9", "no write with read", int'(mem_wr_o), 0);
        @(negedge clk);
        chk(mem_rd_o && mem_addr_o == 8'd1, "R2", "count read next", int'(mem_addr_o), 1);
        wait_idle();
        chk(mem[12 + 7] == 8'h11, "R3", "first post slot", int'(mem[19]), 8'h11);

        // R6: disabled request dropped
        clear_mon();
        mem[1] = 8'd9;
        enable_i = 1'b0; req_valid_i = 1'b1; req_type_i = 8'h22;
        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(nops == 0, "R6", "accesses when disabled", nops, 0);
        chk(nbusy == 0, "R6", "busy cycles when disabled", nbusy, 0);
        chk(mem[1] == 8'd9, "R6", "count untouched", int'(mem[1]), 9);

        // R7: held request accepted after first completes
        clear_mon();
        mem[0] = 8'd50; mem[1] = 8'd1;
        enable_i = 1'b1; req_valid_i = 1'b1; req_type_i = 8'h33;
        @(negedge clk);
        req_type_i = 8'h44;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        wait_idle();
        chk(mem[12 + 51] == 8'h33, "R7", "first held post", int'(mem[63]), 8'h33);
        chk(mem[12 + 0] == 8'h44, "R7", "second held post wraps", int'(mem[12]), 8'h44);
        chk(mem[1] == 8'd3, "R4", "count after two posts", int'(mem[1]), 3);
        chk(nops == 8, "R8", "accesses for two posts", nops, 8);

        // R4: count wrap and out-of-range head
        post_one(255, 255, 8'h5A);
        post_one(200, 100, 8'hC3);

        // near-exhaustive sweep: every legal head against every count
        for (int h = 0; h < 52; h++) begin
            for (int c = 0; c < 256; c++) begin
                post_one(h, c, (h * 7 + c * 3 + 1) % 256);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule